// File: doc/BRIEF.md
# Three-Port GPIO Register Bank with Pin Ownership

This block holds the output latches of three general-purpose I/O ports of a small 8-bit controller and serves them over a byte-wide register bus. The first port has eight pins and the second and third have two pins each. The bus writes the output latches. It reads back the live pad levels after a two-flop synchronizer, not the latch contents. For every pin, the pad output-enable follows a per-pin enable input.

On the eight-pin port, other functions can take over some of the pins:
- Four pins (bits 6..3) can be handed, one pin at a time, to a serial-peripheral engine.
- Bit 2 can be taken by a regulator output.
- Bits 1..0 can be handed to a USB transceiver as D-/D+.
- A force mode lets the output latch drive D-/D+ directly while USB mode is on.

While a function owns a pin, the latch of that pin still takes bus writes. The written value reaches the pad again once the pin returns to GPIO.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset every output latch is 0, so every GPIO-owned pad output is 0.
- R2: A bus write to address 0x01, 0x02 or 0x03 loads that port's latch. The value appears on its GPIO-owned pad outputs after the next clock edge. The pad output-enable of a GPIO-owned pin equals its enable input.
- R3: A read returns the pad input levels of the addressed port, not the latch. A pad change is visible on the read data after two clock edges and not after one.
- R4: On addresses 0x02 and 0x03 only bits 1..0 exist. Read data bits 7..2 are 0, and write data bits 7..2 have no effect.
- R5: A write to any other address changes no latch, and a read of any other address returns 0.
- R6: With the regulator enable set, pin 2 of the first port drives the regulator level input with its output-enable at 1. The latch bit 2 is ignored.
- R7: With USB mode off, bits 1..0 of the first port are plain GPIO, and the force bit has no effect.
- R8: With USB mode on and force off, bit 0 drives the transceiver D+ level and bit 1 drives the D- level. Both output-enables equal the transceiver enable.
- R9: With USB mode on and force on, bits 1..0 drive latch bits 1..0 with both output-enables at 1.
- R10: Select bit k (k = 0..3) hands pin k+3 of the first port to the serial engine: bit 3 is slave select, bit 4 clock, bit 5 MOSI and bit 6 MISO. The pad output and output-enable of that pin then take the engine's output and enable bit k.
- R11: A write to a pin owned by another function still loads the latch. When the pin returns to GPIO, it drives the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| p1_pad_in | input | 8 | First port pad levels |
| p1_oe | input | 8 | First port GPIO output enables |
| p1_pad_out | output | 8 | First port pad drive levels |
| p1_pad_oe | output | 8 | First port pad output enables |
| p2_pad_in | input | 2 | Second port pad levels |
| p2_oe | input | 2 | Second port output enables |
| p2_pad_out | output | 2 | Second port drive levels |
| p2_pad_oe | output | 2 | Second port pad output enables |
| p3_pad_in | input | 2 | Third port pad levels |
| p3_oe | input | 2 | Third port output enables |
| p3_pad_out | output | 2 | Third port drive levels |
| p3_pad_oe | output | 2 | Third port pad output enables |
| spi_sel | input | 4 | Per-pin serial-engine ownership of bits 6..3 |
| spi_out | input | 4 | Serial-engine drive levels |
| spi_oe | input | 4 | Serial-engine output enables |
| vreg_en | input | 1 | Regulator takes bit 2 |
| vreg_drv | input | 1 | Regulator drive level |
| usb_mode | input | 1 | USB owns bits 1..0 |
| usb_force | input | 1 | Latch drives D-/D+ while USB mode is on |
| usb_dp_out | input | 1 | Transceiver D+ level |
| usb_dm_out | input | 1 | Transceiver D- level |
| usb_oe | input | 1 | Transceiver output enable |

## Verification
Two functions can land on the same clock edge: a bus write to the first port, and a change of pin ownership on that port. The bench provokes this by writing the first port while serial-engine selects are set and while USB owns the low pins. It then releases ownership or turns on force mode, and each time expects the pad to show the value just written. A second collision is a pad input change during a bus write. It is judged by requiring that the read data tracks the pad two edges later, whatever the latch holds.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants of the GPIO register bank.
// Assumes an 8-bit data bus; the addresses are byte addresses.
package gpio_bank_pkg;
    localparam int DATA_W  = 8;
    localparam int P1_W    = 8;
    localparam int P23_W   = 2;
    localparam int SPI_LO  = 3;
    localparam int SPI_N   = 4;
    localparam int VREG_B  = 2;
    localparam logic [7:0] P1_ADDR = 8'h01;
    localparam logic [7:0] P2_ADDR = 8'h02;
    localparam logic [7:0] P3_ADDR = 8'h03;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchronizer for pad input levels.
// Assumes that pad inputs are asynchronous and that each bit is synchronized on its own.
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;
    logic [1:0]   warm;

    // two-stage capture of pad levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end

    // counts edges since reset, for the checker only
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_out_latch.sv
// Module: output latch of one port, loaded by a decoded write strobe.
// Assumes that the strobe is already decoded for this port's address.
module gpio_out_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // load on write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

    // R2
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(d)));
    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/gpio_p1_owner_mux.sv
// Module: decides who drives each pin of the eight-pin port.
// Bit 7 is always GPIO. Bits 6..3 go to the serial engine per select bit.
// Bit 2 goes to the regulator. Bits 1..0 go to USB, or to the latch in force mode.
// Assumes that the owner inputs are stable in the clock domain of the bank.
module gpio_p1_owner_mux
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [P1_W-1:0]   latch,
    input  logic [P1_W-1:0]   gpio_oe,
    input  logic [SPI_N-1:0]  spi_sel,
    input  logic [SPI_N-1:0]  spi_out,
    input  logic [SPI_N-1:0]  spi_oe,
    input  logic              vreg_en,
    input  logic              vreg_drv,
    input  logic              usb_mode,
    input  logic              usb_force,
    input  logic              usb_dp_out,
    input  logic              usb_dm_out,
    input  logic              usb_oe,
    output logic [P1_W-1:0]   pad_out,
    output logic [P1_W-1:0]   pad_oe
);
    // bit 7: always GPIO
    assign pad_out[P1_W-1] = latch[P1_W-1];
    assign pad_oe[P1_W-1]  = gpio_oe[P1_W-1];

    // bits 6..3: per-pin serial-engine ownership
    for (genvar k = 0; k < SPI_N; k++) begin : g_spi
        assign pad_out[SPI_LO+k] = spi_sel[k] ? spi_out[k] : latch[SPI_LO+k];
        assign pad_oe[SPI_LO+k]  = spi_sel[k] ? spi_oe[k]  : gpio_oe[SPI_LO+k];
    end

    // bit 2: regulator overrides GPIO
    always_comb begin
        pad_out[VREG_B] = vreg_en ? vreg_drv : latch[VREG_B];
        pad_oe[VREG_B]  = vreg_en ? 1'b1     : gpio_oe[VREG_B];
    end

    // bits 1..0: GPIO, transceiver, or forced from the latch
    always_comb begin
        if (!usb_mode) begin
            pad_out[1:0] = latch[1:0];
            pad_oe[1:0]  = gpio_oe[1:0];
        end else if (usb_force) begin
            pad_out[1:0] = latch[1:0];
            pad_oe[1:0]  = 2'b11;
        end else begin
            pad_out[1:0] = {usb_dm_out, usb_dp_out};
            pad_oe[1:0]  = {2{usb_oe}};
        end
    end

    // R6
    vreg_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vreg_en |-> (pad_oe[VREG_B] && pad_out[VREG_B] == vreg_drv));
    // R9
    usb_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_mode && usb_force) |-> (pad_oe[1:0] == 2'b11 && pad_out[1:0] == latch[1:0]));
    // R8
    usb_xcvr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_mode && !usb_force) |-> (pad_out[1] == usb_dm_out && pad_out[0] == usb_dp_out));
    // R7
    usb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !usb_mode |-> (pad_out[1:0] == latch[1:0] && pad_oe[1:0] == gpio_oe[1:0]));
endmodule

// File: rtl/gpio_port_bank.sv
// Module: top of the three-port GPIO register bank.
// Decodes bus writes into the three latches and muxes synchronized pad levels onto the read data.
// Assumes one-cycle write strobes and a read data path that is sampled combinationally.
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [P1_W-1:0]   p1_pad_in,
    input  logic [P1_W-1:0]   p1_oe,
    output logic [P1_W-1:0]   p1_pad_out,
    output logic [P1_W-1:0]   p1_pad_oe,
    input  logic [P23_W-1:0]  p2_pad_in,
    input  logic [P23_W-1:0]  p2_oe,
    output logic [P23_W-1:0]  p2_pad_out,
    output logic [P23_W-1:0]  p2_pad_oe,
    input  logic [P23_W-1:0]  p3_pad_in,
    input  logic [P23_W-1:0]  p3_oe,
    output logic [P23_W-1:0]  p3_pad_out,
    output logic [P23_W-1:0]  p3_pad_oe,
    input  logic [SPI_N-1:0]  spi_sel,
    input  logic [SPI_N-1:0]  spi_out,
    input  logic [SPI_N-1:0]  spi_oe,
    input  logic              vreg_en,
    input  logic              vreg_drv,
    input  logic              usb_mode,
    input  logic              usb_force,
    input  logic              usb_dp_out,
    input  logic              usb_dm_out,
    input  logic              usb_oe
);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(P1_ADDR);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(P2_ADDR);
    localparam logic [ADDR_W-1:0] A3 = ADDR_W'(P3_ADDR);
    localparam int PAD_W = DATA_W - P23_W;

    logic [P1_W-1:0]  p1_q, p1_sync;
    logic [P23_W-1:0] p2_q, p3_q, p2_sync, p3_sync;
    logic             we1, we2, we3;

    // write strobe decode
    assign we1 = bus_wr && (bus_addr == A1);
    assign we2 = bus_wr && (bus_addr == A2);
    assign we3 = bus_wr && (bus_addr == A3);

    gpio_out_latch #(.W(P1_W))  u_l1 (.clk(clk), .rst_n(rst_n), .we(we1), .d(bus_wdata),          .q(p1_q));
    gpio_out_latch #(.W(P23_W)) u_l2 (.clk(clk), .rst_n(rst_n), .we(we2), .d(bus_wdata[P23_W-1:0]), .q(p2_q));
    gpio_out_latch #(.W(P23_W)) u_l3 (.clk(clk), .rst_n(rst_n), .we(we3), .d(bus_wdata[P23_W-1:0]), .q(p3_q));

    gpio_in_sync #(.W(P1_W))  u_s1 (.clk(clk), .rst_n(rst_n), .d(p1_pad_in), .q(p1_sync));
    gpio_in_sync #(.W(P23_W)) u_s2 (.clk(clk), .rst_n(rst_n), .d(p2_pad_in), .q(p2_sync));
    gpio_in_sync #(.W(P23_W)) u_s3 (.clk(clk), .rst_n(rst_n), .d(p3_pad_in), .q(p3_sync));

    gpio_p1_owner_mux u_mux (
        .clk(clk), .rst_n(rst_n), .latch(p1_q), .gpio_oe(p1_oe),
        .spi_sel(spi_sel), .spi_out(spi_out), .spi_oe(spi_oe),
        .vreg_en(vreg_en), .vreg_drv(vreg_drv),
        .usb_mode(usb_mode), .usb_force(usb_force),
        .usb_dp_out(usb_dp_out), .usb_dm_out(usb_dm_out), .usb_oe(usb_oe),
        .pad_out(p1_pad_out), .pad_oe(p1_pad_oe)
    );

    // small ports are pure GPIO
    assign p2_pad_out = p2_q;
    assign p2_pad_oe  = p2_oe;
    assign p3_pad_out = p3_q;
    assign p3_pad_oe  = p3_oe;

    // read data select from synchronized pad levels
    always_comb begin
        unique case (bus_addr)
            A1:      bus_rdata = p1_sync;
            A2:      bus_rdata = {{PAD_W{1'b0}}, p2_sync};
            A3:      bus_rdata = {{PAD_W{1'b0}}, p3_sync};
            default: bus_rdata = '0;
        endcase
    end

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A2 || bus_addr == A3) |-> (bus_rdata[DATA_W-1:P23_W] == '0));
    // R5
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_addr == A1 || bus_addr == A2 || bus_addr == A3) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_port_bank_tb.sv
// Directed bench for the GPIO register bank. Each task checks its own scenario.
module gpio_port_bank_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] p1_pad_in = '0, p1_oe = '0, p1_pad_out, p1_pad_oe;
    logic [1:0] p2_pad_in = '0, p2_oe = '0, p2_pad_out, p2_pad_oe;
    logic [1:0] p3_pad_in = '0, p3_oe = '0, p3_pad_out, p3_pad_oe;
    logic [3:0] spi_sel = '0, spi_out = '0, spi_oe = '0;
    logic vreg_en = 0, vreg_drv = 0, usb_mode = 0, usb_force = 0;
    logic usb_dp_out = 0, usb_dm_out = 0, usb_oe = 0;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port_bank dut_i (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 p1 out", p1_pad_out, 8'h00);
        check("R1 p2/p3 out", {4'h0, p2_pad_out, p3_pad_out}, 8'h00);
    endtask

    task automatic t_write();
        p1_oe = 8'hF0; p2_oe = 2'b01; p3_oe = 2'b10;
        bus_write(8'h01, 8'hA5);
        check("R2 p1 out", p1_pad_out, 8'hA5);
        check("R2 p1 oe", p1_pad_oe, 8'hF0);
        bus_write(8'h02, 8'h02);
        bus_write(8'h03, 8'h01);
        check("R2 p2/p3 out", {4'h0, p2_pad_out, p3_pad_out}, 8'h09);
        check("R2 p2/p3 oe", {4'h0, p2_pad_oe, p3_pad_oe}, 8'h06);
    endtask

    task automatic t_readback();
        @(negedge clk);
        bus_addr = 8'h01; p1_pad_in = 8'h3C;
        @(negedge clk);
        check("R3 one edge not yet", bus_rdata, 8'h00);
        @(negedge clk);
        check("R3 pads not latch", bus_rdata, 8'h3C);
    endtask

    task automatic t_reserved();
        bus_write(8'h02, 8'hFC);
        check("R4 rsvd write", {6'h0, p2_pad_out}, 8'h00);
        p2_pad_in = 2'b11; p3_pad_in = 2'b10;
        bus_addr = 8'h02;
        repeat (2) @(negedge clk);
        check("R4 p2 read", bus_rdata, 8'h03);
        bus_addr = 8'h03;
        #1 check("R4 p3 read", bus_rdata, 8'h02);
    endtask

    task automatic t_unmapped();
        p1_pad_in = 8'hFF;
        bus_write(8'h00, 8'hFF);
        bus_write(8'h04, 8'hFF);
        bus_write(8'h81, 8'hFF);
        check("R5 p1 unchanged", p1_pad_out, 8'hA5);
        check("R5 p2/p3 unchanged", {4'h0, p2_pad_out, p3_pad_out}, 8'h01);
        bus_addr = 8'h04;
        repeat (2) @(negedge clk);
        check("R5 read zero", bus_rdata, 8'h00);
    endtask

    task automatic t_vreg();
        @(negedge clk);
        vreg_en = 1; vreg_drv = 1; p1_oe = 8'h00;
        #1 check("R6 vreg own", {p1_pad_out[2], p1_pad_oe[2]}, 8'h03);
        vreg_drv = 0;
        #1 check("R6 vreg level", {p1_pad_out[2], p1_pad_oe[2]}, 8'h01);
        // R11: write under ownership, release
        bus_write(8'h01, 8'h04);
        check("R11 vreg still owns", {7'h0, p1_pad_out[2]}, 8'h00);
        vreg_en = 0;
        #1 check("R11 latch back", {7'h0, p1_pad_out[2]}, 8'h01);
    endtask

    task automatic t_usb();
        @(negedge clk);
        p1_oe = 8'h00;
        bus_write(8'h01, 8'h02);
        usb_force = 1;
        #1 check("R7 force ignored", {4'h0, p1_pad_out[1:0], p1_pad_oe[1:0]}, 8'h08);
        usb_mode = 1; usb_force = 0; usb_dp_out = 1; usb_dm_out = 0; usb_oe = 1;
        #1 check("R8 xcvr", {4'h0, p1_pad_out[1:0], p1_pad_oe[1:0]}, 8'h07);
        usb_dp_out = 0; usb_dm_out = 1; usb_oe = 0;
        #1 check("R8 xcvr dm", {4'h0, p1_pad_out[1:0], p1_pad_oe[1:0]}, 8'h08);
        bus_write(8'h01, 8'h01);
        usb_force = 1;
        #1 check("R9 force", {4'h0, p1_pad_out[1:0], p1_pad_oe[1:0]}, 8'h07);
        bus_write(8'h01, 8'h02);
        check("R9 force follows write", {6'h0, p1_pad_out[1:0]}, 8'h02);
        usb_force = 0; usb_mode = 0;
    endtask

    task automatic t_spi();
        @(negedge clk);
        p1_oe = 8'h00;
        bus_write(8'h01, 8'h00);
        spi_sel = 4'b0101; spi_out = 4'b1111; spi_oe = 4'b0100;
        #1 check("R10 spi pins", p1_pad_out, 8'h28);
        check("R10 spi oe", p1_pad_oe, 8'h20);
        spi_sel = 4'b1111;
        bus_write(8'h01, 8'h78);
        spi_out = 4'b0000;
        #1 check("R11 spi owns", p1_pad_out & 8'h78, 8'h00);
        spi_sel = 4'b0000;
        #1 check("R11 spi released", p1_pad_out, 8'h78);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_readback();
        t_reserved();
        t_unmapped();
        t_vreg();
        t_usb();
        t_spi();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual running expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule